// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a virtual address into a physical address by walking a page table with two levels held in memory. A request is a single-cycle pulse that carries the virtual address and whether the access is a read or a write. The walker then makes two reads through a simple read port. The first read fetches the entry of the first-level table, and that entry names the page holding the second-level table. The second read fetches the leaf entry. The block then joins the leaf's physical page number with the page offset.

Once the walk is over, the block raises a completion flag for exactly one cycle. In that cycle it shows the translated address and the valid, dirty and referenced bits of the last entry it read. It also shows a one-hot error code. That code covers a missing entry at either level, a write to a page that is not writable, and a read of a page that is not readable. The walker serves one request at a time. The read port returns data in the cycle after the address is presented.

Top module: `pt_walker`

## Requirements
- R1: While `rst` is high at a clock edge, the walker goes to state 00 on that edge. After such an edge, `walk_done`, `mem_rd`, `paddr` and `err_code` are all zero.
- R2: In state 00 with `req_valid` low, the walker stays in state 00 and never asserts `mem_rd`.
- R3: A request accepted at edge E0 gives state 01 in the next cycle, with `mem_rd` high and `mem_addr` = ROOT_BASE + 4 × vaddr[31:22]. The virtual address is latched, so later changes on `vaddr` do not affect the walk.
- R4: Two cycles after the first read, when the first-level entry is valid, state 10 presents `mem_rd` high and `mem_addr` = {entry[31:12], 12'h000} + 4 × vaddr[21:12].
- R5: `mem_rd` is high for one cycle per level and low in the cycle that follows. For a walk that reaches the leaf, `walk_done` is high only in the cycle after edge E0+4. In the next cycle the state is back to 00.
- R6: On success, `err_code` is 000 and `paddr` = {leaf[31:12], vaddr[11:0]}.
- R7: While `walk_done` is high, `pte_valid`, `pte_dirty` and `pte_ref` show bits 0, 3 and 4 of the last entry read.
- R8: A first-level entry with bit 0 clear ends the walk. `walk_done` and `err_code` = 001 appear in the cycle after E0+2, in state 01, with `paddr` = 0. No second read is made.
- R9: A leaf entry with bit 0 clear reports `err_code` = 001 with `paddr` = 0. This takes priority over the permission checks.
- R10: A write (`req_write` = 1) to a valid leaf with bit 2 (writable) clear reports `err_code` = 010. This code is reported only in state 10.
- R11: A read (`req_write` = 0) of a valid leaf with bit 1 (readable) clear reports `err_code` = 100. This code is reported only in state 10.
- R12: `paddr` is zero in every cycle where `walk_done` is low or `err_code` is not 000. `err_code` is non-zero only while `walk_done` is high.
- R13: A request that arrives while a walk is in progress is ignored. It neither alters the result nor starts a second walk.
- R14: Raising `rst` during a walk aborts the walk. The next request then walks normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Single-cycle translation request |
| req_write | input | 1 | Access type: 0 read, 1 write |
| vaddr | input | 32 | Virtual address: index 1 [31:22], index 2 [21:12], offset [11:0] |
| mem_rd | output | 1 | Page-table read strobe |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rdata | input | 32 | Entry returned one cycle after `mem_rd` |
| paddr | output | 32 | Translated address, valid in the completion cycle |
| walk_done | output | 1 | One-cycle completion flag |
| pte_valid | output | 1 | Valid bit of the last entry read |
| pte_dirty | output | 1 | Dirty bit of the last entry read |
| pte_ref | output | 1 | Referenced bit of the last entry read |
| err_code | output | 3 | One-hot error: 001 fault, 010 not writable, 100 not readable |
| walk_state | output | 2 | 00 idle, 01 first level, 10 second level |

## Verification
The assertions rely on the read port behaving as a synchronous memory. They assume `mem_rdata` holds the entry for the address of the previous cycle's strobe, and that `rst` is driven only between clock edges. The bench supplies a memory that follows this rule, with contents that are arithmetic functions of the address. The flag patterns cycle through all 32 combinations across the second-level indices. The bench changes every input on the falling edge. It applies requests both at idle and in the middle of a walk, so the busy case is covered without creating two walks at once.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_LVL1 = 2'b01,
        ST_LVL2 = 2'b10
    } walk_st_e;

    typedef enum logic [1:0] {
        PH_ISSUE  = 2'b00,
        PH_WAIT   = 2'b01,
        PH_REPORT = 2'b10
    } walk_ph_e;

    localparam int FLAG_W = 5;
    localparam int FLG_V  = 0;
    localparam int FLG_R  = 1;
    localparam int FLG_W  = 2;
    localparam int FLG_D  = 3;
    localparam int FLG_A  = 4;

    localparam logic [2:0] ERR_NONE  = 3'b000;
    localparam logic [2:0] ERR_FAULT = 3'b001;
    localparam logic [2:0] ERR_NOWR  = 3'b010;
    localparam logic [2:0] ERR_NORD  = 3'b100;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int PA_W  = 32,
    parameter int IDX_W = 10,
    parameter int SHIFT = 2
) (
    input  logic [PA_W-1:0]  base,
    input  logic [IDX_W-1:0] idx,
    output logic [PA_W-1:0]  addr
);
    // entry address: table base plus index scaled by entry size
    assign addr = base + (PA_W'(idx) << SHIFT);
endmodule

// File: rtl/ptw_perm_check.sv
module ptw_perm_check
    import ptw_pkg::*;
(
    input  logic       ent_valid,
    input  logic       ent_read,
    input  logic       ent_write,
    input  logic       is_leaf,
    input  logic       is_write,
    output logic [2:0] err
);
    always_comb begin
        err = ERR_NONE;
        if (!ent_valid) begin
            err = ERR_FAULT;               // missing entry wins at any level
        end else if (is_leaf) begin
            if (is_write && !ent_write)      err = ERR_NOWR;
            else if (!is_write && !ent_read) err = ERR_NORD;
        end
    end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import ptw_pkg::*;
#(
    parameter int              IDX_W     = 10,
    parameter int              OFF_W     = 12,
    parameter int              PA_W      = 32,
    parameter int              PTE_W     = 32,
    parameter logic [PA_W-1:0] ROOT_BASE = 'h0000_4000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       req_valid,
    input  logic                       req_write,
    input  logic [2*IDX_W+OFF_W-1:0]   vaddr,
    output logic                       mem_rd,
    output logic [PA_W-1:0]            mem_addr,
    input  logic [PTE_W-1:0]           mem_rdata,
    output logic [PA_W-1:0]            paddr,
    output logic                       walk_done,
    output logic                       pte_valid,
    output logic                       pte_dirty,
    output logic                       pte_ref,
    output logic [2:0]                 err_code,
    output logic [1:0]                 walk_state
);
    localparam int VA_W      = 2*IDX_W + OFF_W;
    localparam int PPN_W     = PA_W - OFF_W;
    localparam int PTE_BYTES = PTE_W / 8;
    localparam int IDX_SHIFT = $clog2(PTE_BYTES);
    localparam int LEVELS    = 2;

    typedef struct packed {
        walk_st_e           st;
        walk_ph_e           ph;
        logic               wr;
        logic [VA_W-1:0]    va;
        logic [PA_W-1:0]    base;   // second-level table base
        logic [PA_W-1:0]    pa;
        logic [2:0]         err;
        logic [FLAG_W-1:0]  flg;
    } regs_t;

    regs_t q, d;

    // ---- per-level entry address ----
    logic [PA_W-1:0] lvl_addr [LEVELS];

    for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
        logic [PA_W-1:0] tbl_base;
        if (g == 0) begin : g_root
            assign tbl_base = ROOT_BASE;
        end else begin : g_next
            assign tbl_base = q.base;
        end
        ptw_addr_gen #(
            .PA_W  (PA_W),
            .IDX_W (IDX_W),
            .SHIFT (IDX_SHIFT)
        ) u_ag (
            .base (tbl_base),
            .idx  (q.va[VA_W-1-g*IDX_W -: IDX_W]),
            .addr (lvl_addr[g])
        );
    end

    // ---- entry decode ----
    logic [PPN_W-1:0]  rd_ppn;
    logic [FLAG_W-1:0] rd_flg;
    logic              unused_rsvd_bits;
    logic [2:0]        chk_err;

    assign rd_ppn           = mem_rdata[PTE_W-1 -: PPN_W];
    assign rd_flg           = mem_rdata[FLAG_W-1:0];
    assign unused_rsvd_bits = ^mem_rdata[PTE_W-PPN_W-1:FLAG_W];

    ptw_perm_check u_chk (
        .ent_valid (rd_flg[FLG_V]),
        .ent_read  (rd_flg[FLG_R]),
        .ent_write (rd_flg[FLG_W]),
        .is_leaf   (q.st == ST_LVL2),
        .is_write  (q.wr),
        .err       (chk_err)
    );

    // ---- next state ----
    always_comb begin
        d = q;
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.st  = ST_LVL1;
                    d.ph  = PH_ISSUE;
                    d.va  = vaddr;
                    d.wr  = req_write;
                    d.pa  = '0;
                    d.err = ERR_NONE;
                    d.flg = '0;
                end
            end
            ST_LVL1, ST_LVL2: begin
                unique case (q.ph)
                    PH_ISSUE: d.ph = PH_WAIT;
                    PH_WAIT: begin
                        d.flg = rd_flg;
                        if (chk_err != ERR_NONE) begin
                            d.err = chk_err;
                            d.pa  = '0;
                            d.ph  = PH_REPORT;
                        end else if (q.st == ST_LVL1) begin
                            d.st   = ST_LVL2;
                            d.ph   = PH_ISSUE;
                            d.base = {rd_ppn, {OFF_W{1'b0}}};
                        end else begin
                            d.err = ERR_NONE;
                            d.pa  = {rd_ppn, q.va[OFF_W-1:0]};
                            d.ph  = PH_REPORT;
                        end
                    end
                    default: begin
                        d.st  = ST_IDLE;
                        d.ph  = PH_ISSUE;
                        d.pa  = '0;
                        d.err = ERR_NONE;
                        d.flg = '0;
                    end
                endcase
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    // ---- outputs ----
    assign mem_rd     = (q.st != ST_IDLE) && (q.ph == PH_ISSUE);
    assign mem_addr   = (q.st == ST_LVL2) ? lvl_addr[1] : lvl_addr[0];
    assign walk_done  = (q.st != ST_IDLE) && (q.ph == PH_REPORT);
    assign paddr      = q.pa;
    assign err_code   = q.err;
    assign pte_valid  = q.flg[FLG_V];
    assign pte_dirty  = q.flg[FLG_D];
    assign pte_ref    = q.flg[FLG_A];
    assign walk_state = q.st;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst,
    input logic            req_valid,
    input logic            mem_rd,
    input logic [PA_W-1:0] paddr,
    input logic            walk_done,
    input logic            pte_valid,
    input logic [2:0]      err_code,
    input logic [1:0]      walk_state
);
    // R1: a reset edge leaves the walker idle and silent
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> (walk_state == 2'b00 && !walk_done && !mem_rd));

    // R2: idle without request stays idle
    p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (walk_state == 2'b00 && !req_valid) |=> (walk_state == 2'b00));

    // R3 / R4: reads only happen during a walk, one cycle each
    p_read_in_walk_r3: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> (walk_state != 2'b00));
    p_read_single_r4: assert property (@(posedge clk) disable iff (rst)
        mem_rd |=> !mem_rd);

    // R5: completion is a single pulse followed by idle
    p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        walk_done |=> (!walk_done && walk_state == 2'b00));

    // R8 / R9: a fault carries no address and an invalid entry
    p_fault_clean_r8: assert property (@(posedge clk) disable iff (rst)
        (err_code == 3'b001) |-> (paddr == '0 && !pte_valid));

    // R10 / R11: one-hot code, permission errors only at the leaf
    p_err_onehot_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(err_code));
    p_perm_leaf_r11: assert property (@(posedge clk) disable iff (rst)
        (err_code[2] || err_code[1]) |-> (walk_state == 2'b10));

    // R12: address and error visible only in the completion cycle
    p_pa_gated_r12: assert property (@(posedge clk) disable iff (rst)
        (!walk_done || err_code != 3'b000) |-> (paddr == '0));
    p_err_gated_r12: assert property (@(posedge clk) disable iff (rst)
        (err_code != 3'b000) |-> walk_done);

    // R13: a walk in progress is not left before it reports
    p_busy_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (walk_state != 2'b00 && !walk_done) |=> (walk_state != 2'b00));
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_pt_walker_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .mem_rd     (mem_rd),
    .paddr      (paddr),
    .walk_done  (walk_done),
    .pte_valid  (pte_valid),
    .err_code   (err_code),
    .walk_state (walk_state)
);

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
    localparam logic [31:0] ROOT  = 32'h0000_4000;
    localparam logic [31:0] L2LO  = 32'h0010_0000;
    localparam logic [31:0] L2HI  = 32'h0050_0000;
    localparam int          WD_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] vaddr = '0;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic [31:0] mem_rdata = '0;
    logic [31:0] paddr;
    logic        walk_done, pte_valid, pte_dirty, pte_ref;
    logic [2:0]  err_code;
    logic [1:0]  walk_state;

    int n_chk  = 0;
    int n_fail = 0;
    bit ended  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pt_walker #(.ROOT_BASE(ROOT)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .vaddr(vaddr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .paddr(paddr), .walk_done(walk_done), .pte_valid(pte_valid),
        .pte_dirty(pte_dirty), .pte_ref(pte_ref), .err_code(err_code),
        .walk_state(walk_state)
    );

    // ---- arithmetic page-table contents ----
    function automatic logic [4:0] l1_flags(input logic [9:0] i);
        return {i[1], i[0], i[3], i[2], (i[2:0] != 3'd5)};
    endfunction
    function automatic logic [19:0] l2_ppn(input logic [9:0] i, input logic [9:0] j);
        return {i, j} ^ 20'h5A5A5;
    endfunction
    function automatic logic [4:0] l2_flags(input logic [9:0] i, input logic [9:0] j);
        return 5'(i * 3 + j * 7);
    endfunction
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [9:0] i, j;
        if (a >= ROOT && a < ROOT + 32'd4096) begin
            i = 10'((a - ROOT) >> 2);
            return {20'h00100 + 20'(i), 7'b0, l1_flags(i)};
        end else if (a >= L2LO && a < L2HI) begin
            i = 10'((a - L2LO) >> 12);
            j = 10'(a >> 2);
            return {l2_ppn(i, j), 7'b0, l2_flags(i, j)};
        end
        return 32'h0;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mem_word(mem_addr);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_walk(input int i, input int j, input logic [11:0] off, input bit wr, input bit poke);
        logic [9:0]  ii = 10'(i);
        logic [9:0]  jj = 10'(j);
        logic [31:0] va = {ii, jj, off};
        logic [4:0]  f1 = l1_flags(ii);
        logic [4:0]  f2 = l2_flags(ii, jj);
        logic [31:0] a1 = ROOT + {20'h0, ii, 2'b00};
        logic [31:0] a2 = {20'h00100 + 20'(ii), 12'h000} + {20'h0, jj, 2'b00};
        logic [2:0]  e_err;
        logic [31:0] e_pa;
        if (!f2[0])            e_err = 3'b001;
        else if (wr && !f2[2]) e_err = 3'b010;
        else if (!wr && !f2[1]) e_err = 3'b100;
        else                   e_err = 3'b000;
        e_pa = (e_err == 3'b000) ? {l2_ppn(ii, jj), off} : 32'h0;

        @(negedge clk);
        req_valid = 1'b1; req_write = wr; vaddr = va;
        @(negedge clk);
        req_valid = 1'b0; vaddr = ~va;
        chk(walk_state == 2'b01 && mem_rd, "R3 first read strobe", {30'b0, walk_state}, 32'h1);
        chk(mem_addr == a1, "R3 first-level address", mem_addr, a1);
        if (poke) begin req_valid = 1'b1; req_write = ~wr; vaddr = 32'hFFFF_FFFF; end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!mem_rd && !walk_done, "R5 wait cycle after read", {31'b0, mem_rd}, 32'h0);
        @(negedge clk);
        if (!f1[0]) begin
            chk(walk_done && walk_state == 2'b01, "R8 early fault done in state 01", {30'b0, walk_state}, 32'h1);
            chk(err_code == 3'b001, "R8 fault code", {29'b0, err_code}, 32'h1);
            chk(paddr == 32'h0, "R8 fault address zero", paddr, 32'h0);
            chk({pte_ref, pte_dirty, pte_valid} == {f1[4], f1[3], f1[0]}, "R7 first-level flags",
                {29'b0, pte_ref, pte_dirty, pte_valid}, {29'b0, f1[4], f1[3], f1[0]});
            @(negedge clk);
            chk(!walk_done && walk_state == 2'b00 && !mem_rd, "R8 no second read",
                {30'b0, walk_state}, 32'h0);
        end else begin
            chk(walk_state == 2'b10 && mem_rd, "R4 second read strobe", {30'b0, walk_state}, 32'h2);
            chk(mem_addr == a2, "R4 second-level address", mem_addr, a2);
            @(negedge clk);
            chk(!walk_done && !mem_rd, "R5 no early done", {31'b0, walk_done}, 32'h0);
            @(negedge clk);
            chk(walk_done && walk_state == 2'b10, "R5 done at E0+4", {31'b0, walk_done}, 32'h1);
            if (e_err == 3'b000)      chk(err_code == e_err, "R6 no error", {29'b0, err_code}, {29'b0, e_err});
            else if (e_err == 3'b001) chk(err_code == e_err, "R9 leaf fault", {29'b0, err_code}, {29'b0, e_err});
            else if (e_err == 3'b010) chk(err_code == e_err, "R10 not writable", {29'b0, err_code}, {29'b0, e_err});
            else                      chk(err_code == e_err, "R11 not readable", {29'b0, err_code}, {29'b0, e_err});
            chk(paddr == e_pa, "R6 translated address", paddr, e_pa);
            chk({pte_ref, pte_dirty, pte_valid} == {f2[4], f2[3], f2[0]}, "R7 leaf flags",
                {29'b0, pte_ref, pte_dirty, pte_valid}, {29'b0, f2[4], f2[3], f2[0]});
            @(negedge clk);
            chk(!walk_done && walk_state == 2'b00 && paddr == 32'h0 && err_code == 3'b000,
                "R12 outputs cleared after done", paddr, 32'h0);
            if (poke) chk(!mem_rd, "R13 busy request ignored", {31'b0, mem_rd}, 32'h0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(walk_state == 2'b00 && !walk_done && !mem_rd && paddr == 0 && err_code == 0,
            "R1 reset state", {30'b0, walk_state}, 32'h0);
        rst = 1'b0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            chk(!mem_rd && walk_state == 2'b00, "R2 idle without request", {31'b0, mem_rd}, 32'h0);
        end
        for (int i = 0; i < 34; i++) begin
            int ix = (i < 32) ? i : ((i == 32) ? 512 : 1023);
            for (int j = 0; j < 9; j++) begin
                int jx = (j < 8) ? j : 1023;
                for (int w = 0; w < 2; w++) begin
                    logic [11:0] off = (j == 3) ? 12'hFFF : 12'((ix * 37 + jx * 11 + w * 5) & 12'hFFF);
                    do_walk(ix, jx, off, w[0], (j == 2));
                end
            end
        end
        // R14: reset in the middle of a walk
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; vaddr = {10'd1, 10'd1, 12'h123};
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(walk_state == 2'b00 && !walk_done && !mem_rd && paddr == 0, "R14 abort on reset",
            {30'b0, walk_state}, 32'h0);
        repeat (3) begin
            @(negedge clk);
            chk(!walk_done && !mem_rd, "R14 nothing after abort", {31'b0, walk_done}, 32'h0);
        end
        do_walk(6, 3, 12'h0AB, 1'b0, 1'b0);
        do_walk(6, 3, 12'h0AB, 1'b1, 1'b0);
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule